// File: doc/BRIEF.md
# I2C Serial Memory Target Bus Engine

This block is the bit-level front end of a small serial memory that acts as a target on a two-wire I2C bus. It receives the bus clock and data lines, already synchronised to a faster system clock. It filters out short glitches on both lines and recognises START, repeated START and STOP. It shifts bytes in and out most significant bit first and pulls the data line low in the acknowledge slot.

The first byte after a START selects the device. Its upper four bits carry a fixed type code, two bits are compared with strap inputs, one bit is the ninth memory address bit and the lowest bit gives the direction. The block reports byte-level events to a memory controller as single-cycle pulses, together with the received byte: select matched, address byte, write data byte, and master acknowledge or no-acknowledge after a read byte. The controller returns the acknowledge decision for each write data byte and supplies the byte to be transmitted.

While the controller reports a running internal write cycle, the block ignores the bus entirely. A master can therefore poll for completion by repeating START plus select until an acknowledge comes back. The block also reports the bit position within the current byte, so the controller can tell whether a STOP came right after an acknowledged byte.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset the data line is not pulled (`sda_pull_o`=0), `bit_pos_o` is 0 and no event pulse is given.
- R2: A level change on either line that lasts fewer than `FILT_CYC` system clocks is ignored. It produces no START or STOP and counts no clock edge.
- R3: A falling data line while the clock is high produces a one-cycle `start_o`. A rising data line while the clock is high produces a one-cycle `stop_o` and returns the block to standby. At most one event pulse is active per cycle.
- R4: A select byte matches when bits 7..4 equal 1010, bit 3 equals `ce_strap_i[1]` and bit 2 equals `ce_strap_i[0]`. On a match the block pulls the data line low during the 9th clock and pulses `sel_o`, with `sel_a8_o` = bit 1 and `sel_rw_o` = bit 0 (1 = read, 0 = write).
- R5: A select byte that does not match gets no acknowledge. The block then ignores the bus until the next START, so later bytes are neither acknowledged nor reported.
- R6: After a write select, the next byte is acknowledged and reported with a one-cycle `addr_o` pulse and the byte on `rx_byte_o`.
- R7: Each later byte of a write is reported with a one-cycle `wdat_o` pulse and the byte on `rx_byte_o`. It is acknowledged only if `wack_i` is 1 at the clock fall that opens the acknowledge slot.
- R8: In a read, `rd_data_i` is taken at the clock fall that starts each byte and sent MSB first: `sda_pull_o` is the inverse of the bit. The pull only turns on while the clock line is low.
- R9: After a read byte, a low data line at the 9th clock rise pulses `mack_o` and the next byte follows. A high line pulses `mnack_o` and returns the block to standby, where it stops driving until the next START.
- R10: A repeated START in any state, including partway through a byte, abandons the current byte and restarts select-byte reception.
- R11: While `wr_busy_i` is 1, the block acknowledges nothing, including a matching select byte, and reports no START, select or data event.
- R12: `bit_pos_o` counts the clock rises since the last byte boundary (0..8) and holds its value through a STOP. A STOP right after an acknowledged byte therefore shows 1, the STOP's own clock rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| ce_strap_i | input | 2 | Strap values compared with select bits 3 and 2 |
| wr_busy_i | input | 1 | Internal write cycle running; bus is ignored |
| wack_i | input | 1 | Acknowledge decision for the current write data byte |
| rd_data_i | input | 8 | Byte to transmit in a read |
| sda_pull_o | output | 1 | Pull the data line low |
| start_o | output | 1 | START or repeated START seen |
| stop_o | output | 1 | STOP seen |
| sel_o | output | 1 | Matching select byte received |
| sel_rw_o | output | 1 | Direction bit of the last matching select |
| sel_a8_o | output | 1 | Ninth address bit of the last matching select |
| addr_o | output | 1 | Address byte received |
| wdat_o | output | 1 | Write data byte received |
| mack_o | output | 1 | Master acknowledged a read byte |
| mnack_o | output | 1 | Master did not acknowledge a read byte |
| rx_byte_o | output | 8 | Last received byte |
| bit_pos_o | output | 4 | Clock rises since the last byte boundary |

## Verification
Select decoding is swept over all 256 byte values with one strap setting, and the straps are then swept with matching and mismatching codes. This separates type-code, strap and direction errors. Write sequences set the controller's acknowledge decision both ways, and read sequences end with a master acknowledge and then a no-acknowledge, followed by extra clocks that must find the line released. Repeated STARTs are placed both after a whole byte and partway through the select byte. STOPs come both right after an acknowledge and mid-byte, which tells a correct bit position from one off by the STOP's clock. Glitches shorter than the filter window on the data line while the clock is high, and on the clock line while it is low, separate a working filter from none.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_ADDR,
        ST_WR,
        ST_RD
    } eng_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic sel;
        logic addr;
        logic wdat;
        logic mack;
        logic mnack;
    } ev_t;

endpackage

// File: rtl/i2cm_deglitch.sv
module i2cm_deglitch #(
    parameter int   FILT_CYC = 13,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    output logic lvl_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d = flt_q;
        if (in_i != flt_q.lvl) begin
            if (flt_q.cnt == CW'(FILT_CYC - 1)) begin
                flt_d.lvl = in_i;
                flt_d.cnt = '0;
            end else begin
                flt_d.cnt = flt_q.cnt + 1'b1;
            end
        end else begin
            flt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '{lvl: RST_VAL, cnt: '0};
        end else begin
            flt_q <= flt_d;
        end
    end

    assign lvl_o = flt_q.lvl;

    // R2: the filtered level only moves to a value the raw input held
    a_r2_change_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q.lvl != $past(flt_q.lvl)) |-> ($past(in_i) == flt_q.lvl));

endmodule

// File: rtl/i2cm_cond_det.sv
module i2cm_cond_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f_i,
    input  logic sda_f_i,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_f_i;
        prev_d.sda = sda_f_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            prev_q <= prev_d;
        end
    end

    assign rise_o  = scl_f_i & ~prev_q.scl;
    assign fall_o  = ~scl_f_i & prev_q.scl;
    assign start_o = scl_f_i & prev_q.scl & prev_q.sda & ~sda_f_i;
    assign stop_o  = scl_f_i & prev_q.scl & ~prev_q.sda & sda_f_i;

    // R3: bus conditions and clock edges are mutually exclusive
    a_r3_one_condition: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_o, fall_o, start_o, stop_o}));

endmodule

// File: rtl/i2cm_byte_eng.sv
module i2cm_byte_eng
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl_i,
    input  logic              sda_lvl_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [1:0]        ce_strap_i,
    input  logic              wr_busy_i,
    input  logic              wack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              sda_pull_o,
    output ev_t               ev_o,
    output logic              rw_o,
    output logic              a8_o,
    output logic [DATA_W-1:0] rx_o,
    output logic [CNT_W-1:0]  bit_pos_o
);
    localparam logic [CNT_W-1:0] ACK_POS  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(DATA_W - 1);

    typedef struct packed {
        eng_state_t        state;
        logic [CNT_W-1:0]  bit_cnt;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] rx;
        logic              drive;
        logic              rw;
        logic              a8;
        ev_t               ev;
    } eng_t;

    eng_t eng_d, eng_q;

    function automatic logic sel_match(logic [DATA_W-1:0] b, logic [1:0] strap);
        return (b[7:4] == DEV_TYPE) && (b[3:2] == strap);
    endfunction

    always_comb begin
        eng_d    = eng_q;
        eng_d.ev = '0;
        if (wr_busy_i) begin
            eng_d.state = ST_IDLE;
            eng_d.drive = 1'b0;
        end else if (start_i) begin
            eng_d.state    = ST_SEL;
            eng_d.bit_cnt  = '0;
            eng_d.drive    = 1'b0;
            eng_d.ev.start = 1'b1;
        end else if (stop_i) begin
            eng_d.state   = ST_IDLE;
            eng_d.drive   = 1'b0;
            eng_d.ev.stop = 1'b1;
        end else if (eng_q.state != ST_IDLE) begin
            if (rise_i) begin
                if (eng_q.bit_cnt != ACK_POS) begin
                    eng_d.bit_cnt = eng_q.bit_cnt + 1'b1;
                    if (eng_q.state != ST_RD) begin
                        eng_d.sh = {eng_q.sh[DATA_W-2:0], sda_lvl_i};
                        if (eng_q.bit_cnt == LAST_POS) begin
                            eng_d.rx = eng_d.sh;
                            unique case (eng_q.state)
                                ST_SEL: begin
                                    if (sel_match(eng_d.sh, ce_strap_i)) begin
                                        eng_d.ev.sel = 1'b1;
                                        eng_d.rw     = eng_d.sh[0];
                                        eng_d.a8     = eng_d.sh[1];
                                    end else begin
                                        eng_d.state = ST_IDLE;
                                    end
                                end
                                ST_ADDR: eng_d.ev.addr = 1'b1;
                                ST_WR:   eng_d.ev.wdat = 1'b1;
                                default: ;
                            endcase
                        end
                    end
                end else begin
                    eng_d.bit_cnt = '0;
                    unique case (eng_q.state)
                        ST_SEL:  eng_d.state = eng_q.rw ? ST_RD : ST_ADDR;
                        ST_ADDR: eng_d.state = ST_WR;
                        ST_RD: begin
                            if (!sda_lvl_i) begin
                                eng_d.ev.mack = 1'b1;
                            end else begin
                                eng_d.ev.mnack = 1'b1;
                                eng_d.state    = ST_IDLE;
                            end
                        end
                        default: ;
                    endcase
                end
            end else if (fall_i) begin
                if (eng_q.state == ST_RD) begin
                    if (eng_q.bit_cnt == '0) begin
                        eng_d.sh    = rd_data_i;
                        eng_d.drive = ~rd_data_i[DATA_W-1];
                    end else if (eng_q.bit_cnt != ACK_POS) begin
                        eng_d.sh    = {eng_q.sh[DATA_W-2:0], 1'b0};
                        eng_d.drive = ~eng_d.sh[DATA_W-1];
                    end else begin
                        eng_d.drive = 1'b0;
                    end
                end else begin
                    eng_d.drive = (eng_q.bit_cnt == ACK_POS) &&
                                  ((eng_q.state != ST_WR) || wack_i);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{state: ST_IDLE, bit_cnt: '0, sh: '0, rx: '0,
                       drive: 1'b0, rw: 1'b0, a8: 1'b0, ev: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sda_pull_o = eng_q.drive;
    assign ev_o       = eng_q.ev;
    assign rw_o       = eng_q.rw;
    assign a8_o       = eng_q.a8;
    assign rx_o       = eng_q.rx;
    assign bit_pos_o  = eng_q.bit_cnt;

    // R8: the pull is only switched on while the filtered clock is low
    a_r8_pull_rises_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_q.drive) |-> !scl_lvl_i);

    // R11: a running write cycle releases the line and blocks selection
    a_r11_busy_releases: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy_i |=> (!eng_q.drive && !eng_q.ev.sel && !eng_q.ev.start));

    // R5: standby never drives the line
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.state == ST_IDLE) |-> !eng_q.drive);

    // R4: a select pulse always carries a byte that matches type code and straps
    a_r4_sel_matches: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.ev.sel |-> (eng_q.rx[7:4] == DEV_TYPE && eng_q.rx[3:2] == ce_strap_i));

    // R3: at most one event pulse per cycle
    a_r3_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_q.ev));

    // R12: bit position never passes the acknowledge slot
    a_r12_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.bit_cnt <= ACK_POS);

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2cm_pkg::*;
#(
    parameter int FILT_CYC = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic [1:0]  ce_strap_i,
    input  logic        wr_busy_i,
    input  logic        wack_i,
    input  logic [7:0]  rd_data_i,
    output logic        sda_pull_o,
    output logic        start_o,
    output logic        stop_o,
    output logic        sel_o,
    output logic        sel_rw_o,
    output logic        sel_a8_o,
    output logic        addr_o,
    output logic        wdat_o,
    output logic        mack_o,
    output logic        mnack_o,
    output logic [7:0]  rx_byte_o,
    output logic [3:0]  bit_pos_o
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw;
    logic [N_LINES-1:0] filt;
    logic rise, fall, start, stop;
    ev_t  ev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_flt
        i2cm_deglitch #(
            .FILT_CYC (FILT_CYC),
            .RST_VAL  (1'b1)
        ) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .in_i  (raw[g]),
            .lvl_o (filt[g])
        );
    end

    i2cm_cond_det u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f_i (filt[1]),
        .sda_f_i (filt[0]),
        .rise_o  (rise),
        .fall_o  (fall),
        .start_o (start),
        .stop_o  (stop)
    );

    i2cm_byte_eng u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_lvl_i  (filt[1]),
        .sda_lvl_i  (filt[0]),
        .rise_i     (rise),
        .fall_i     (fall),
        .start_i    (start),
        .stop_i     (stop),
        .ce_strap_i (ce_strap_i),
        .wr_busy_i  (wr_busy_i),
        .wack_i     (wack_i),
        .rd_data_i  (rd_data_i),
        .sda_pull_o (sda_pull_o),
        .ev_o       (ev),
        .rw_o       (sel_rw_o),
        .a8_o       (sel_a8_o),
        .rx_o       (rx_byte_o),
        .bit_pos_o  (bit_pos_o)
    );

    assign start_o = ev.start;
    assign stop_o  = ev.stop;
    assign sel_o   = ev.sel;
    assign addr_o  = ev.addr;
    assign wdat_o  = ev.wdat;
    assign mack_o  = ev.mack;
    assign mnack_o = ev.mnack;

endmodule

// File: tb/i2c_mem_target_tb.sv
`timescale 1ns/1ps
module i2c_mem_target_tb;

    localparam int FILT = 3;
    localparam int Q    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic       busy = 1'b0;
    logic       wack = 1'b1;
    logic [7:0] rd_data;
    logic       sda_bus;

    logic       sda_pull, start_p, stop_p, sel_p, sel_rw, sel_a8;
    logic       addr_p, wdat_p, mack_p, mnack_p;
    logic [7:0] rx_byte;
    logic [3:0] bit_pos;

    int n_start = 0, n_stop = 0, n_sel = 0, n_addr = 0, n_wdat = 0;
    int n_mack = 0, n_mnack = 0;
    logic [7:0] l_addr = '0, l_wdat = '0;
    logic       l_rw = 1'b0, l_a8 = 1'b0;
    logic [3:0] l_stop_pos = '0;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    function automatic logic [7:0] rd_pat(int k);
        return 8'h5A ^ 8'(k * 37);
    endfunction

    assign rd_data = rd_pat(n_mack);

    i2c_mem_target #(.FILT_CYC(FILT)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .ce_strap_i (strap),
        .wr_busy_i  (busy),
        .wack_i     (wack),
        .rd_data_i  (rd_data),
        .sda_pull_o (sda_pull),
        .start_o    (start_p),
        .stop_o     (stop_p),
        .sel_o      (sel_p),
        .sel_rw_o   (sel_rw),
        .sel_a8_o   (sel_a8),
        .addr_o     (addr_p),
        .wdat_o     (wdat_p),
        .mack_o     (mack_p),
        .mnack_o    (mnack_p),
        .rx_byte_o  (rx_byte),
        .bit_pos_o  (bit_pos)
    );

    always @(posedge clk) begin
        if (start_p) n_start <= n_start + 1;
        if (stop_p) begin
            n_stop     <= n_stop + 1;
            l_stop_pos <= bit_pos;
        end
        if (sel_p) begin
            n_sel <= n_sel + 1;
            l_rw  <= sel_rw;
            l_a8  <= sel_a8;
        end
        if (addr_p) begin
            n_addr <= n_addr + 1;
            l_addr <= rx_byte;
        end
        if (wdat_p) begin
            n_wdat <= n_wdat + 1;
            l_wdat <= rx_byte;
        end
        if (mack_p)  n_mack  <= n_mack + 1;
        if (mnack_p) n_mnack <= n_mnack + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wc(Q);
        scl_m = 1'b1; wc(Q);
        sda_m = 1'b0; wc(Q);
        scl_m = 1'b0; wc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wc(Q);
        scl_m = 1'b1; wc(Q);
        sda_m = 1'b1; wc(Q);
    endtask

    task automatic send_bit(input logic b, output logic pulled);
        sda_m = b;    wc(Q);
        scl_m = 1'b1; wc(Q);
        pulled = sda_pull;
        scl_m = 1'b0; wc(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic p;
        for (int i = 7; i >= 0; i--) send_bit(b[i], p);
        send_bit(1'b1, ack);
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        logic p;
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b1, p);
            d[i] = ~p;
        end
        send_bit(~give_ack, p);
    endtask

    initial begin
        logic       ack, p;
        logic [7:0] d;
        int         s0, s1, m0;
        wc(5);
        rst_n = 1'b1;
        wc(3);

        // R1: reset state
        chk(sda_pull == 1'b0, "R1 pull after reset", sda_pull, 0);
        chk(bit_pos == 4'd0, "R1 bit_pos after reset", bit_pos, 0);
        chk(n_start + n_stop + n_sel == 0, "R1 no events", n_start + n_stop + n_sel, 0);

        // R4/R5/R8: sweep every select value with strap 2'b10
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            logic       exp;
            b   = 8'(v);
            exp = (b[7:4] == 4'b1010) && (b[3:2] == 2'b10);
            s0  = n_sel;
            bus_start();
            send_byte(b, ack);
            chk(ack == exp, "R4/R5 select ack", ack, exp);
            chk((n_sel - s0) == int'(exp), "R4 sel_o count", n_sel - s0, exp);
            if (exp) begin
                chk(l_rw == b[0] && l_a8 == b[1], "R4 rw/a8 fields",
                    {l_rw, l_a8}, {b[0], b[1]});
                if (b[0]) begin
                    m0 = n_mack;
                    read_byte(1'b0, d);
                    chk(d == rd_pat(m0), "R8 read byte after select", d, rd_pat(m0));
                end
            end
            bus_stop();
        end

        // R4: each strap setting, matching and mismatching
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            wc(2);
            bus_start();
            send_byte({4'b1010, 2'(s), 2'b00}, ack);
            chk(ack == 1'b1, "R4 strap match", ack, 1);
            bus_stop();
            bus_start();
            send_byte({4'b1010, 2'(s ^ 3), 2'b00}, ack);
            chk(ack == 1'b0, "R4 strap mismatch", ack, 0);
            bus_stop();
        end
        strap = 2'b10;
        wc(2);

        // R5: after a mismatch the next byte is ignored
        s0 = n_addr;
        bus_start();
        send_byte(8'hA0, ack);
        chk(ack == 1'b0, "R5 mismatch select", ack, 0);
        send_byte(8'h00, ack);
        chk(ack == 1'b0, "R5 later byte not acked", ack, 0);
        chk(n_addr == s0, "R5 no addr event", n_addr, s0);
        bus_stop();

        // R6/R7/R12: write with address and data
        bus_start();
        send_byte(8'hAA, ack);
        chk(ack == 1'b1 && l_a8 == 1'b1, "R4 a8 set", {ack, l_a8}, 2'b11);
        s0 = n_addr;
        send_byte(8'h35, ack);
        chk(ack == 1'b1, "R6 addr ack", ack, 1);
        chk(n_addr == s0 + 1 && l_addr == 8'h35, "R6 addr event", l_addr, 8'h35);
        wack = 1'b1;
        send_byte(8'h9C, ack);
        chk(ack == 1'b1, "R7 data acked", ack, 1);
        chk(l_wdat == 8'h9C, "R7 data byte", l_wdat, 8'h9C);
        wack = 1'b0;
        s1 = n_wdat;
        send_byte(8'h11, ack);
        chk(ack == 1'b0, "R7 data refused", ack, 0);
        chk(n_wdat == s1 + 1 && l_wdat == 8'h11, "R7 refused byte reported", l_wdat, 8'h11);
        wack = 1'b1;
        bus_stop();
        wc(2);
        chk(l_stop_pos == 4'd1, "R12 stop after ack", l_stop_pos, 1);
        chk(sda_pull == 1'b0, "R3 released after stop", sda_pull, 0);

        // R12: stop mid-byte
        bus_start();
        send_byte(8'hA8, ack);
        send_bit(1'b1, p);
        send_bit(1'b0, p);
        send_bit(1'b1, p);
        bus_stop();
        wc(2);
        chk(l_stop_pos == 4'd4, "R12 stop mid-byte", l_stop_pos, 4);

        // R10/R8/R9: random read via repeated start
        bus_start();
        send_byte(8'hA8, ack);
        send_byte(8'h07, ack);
        s0 = n_start;
        bus_start();
        send_byte(8'hA9, ack);
        chk(ack == 1'b1, "R10 select after restart", ack, 1);
        chk(n_start == s0 + 1, "R3 restart reported", n_start, s0 + 1);
        m0 = n_mack;
        s1 = n_mnack;
        read_byte(1'b1, d);
        chk(d == rd_pat(m0), "R8 first read byte", d, rd_pat(m0));
        chk(n_mack == m0 + 1, "R9 master ack event", n_mack, m0 + 1);
        read_byte(1'b0, d);
        chk(d == rd_pat(m0 + 1), "R8 next read byte", d, rd_pat(m0 + 1));
        chk(n_mnack == s1 + 1, "R9 master nack event", n_mnack, s1 + 1);
        for (int i = 0; i < 9; i++) begin
            send_bit(1'b1, p);
            chk(p == 1'b0, "R9 released after nack", p, 0);
        end
        bus_stop();

        // R10: restart in the middle of the select byte
        s0 = n_start;
        bus_start();
        send_bit(1'b1, p);
        send_bit(1'b0, p);
        send_bit(1'b1, p);
        send_bit(1'b0, p);
        bus_start();
        send_byte(8'hA8, ack);
        chk(ack == 1'b1, "R10 restart mid-byte", ack, 1);
        chk(n_start == s0 + 2, "R10 two starts", n_start, s0 + 2);
        bus_stop();

        // R11: busy ignores the bus
        busy = 1'b1;
        s0 = n_sel;
        s1 = n_start;
        bus_start();
        send_byte(8'hA8, ack);
        chk(ack == 1'b0, "R11 no ack while busy", ack, 0);
        chk(n_sel == s0 && n_start == s1, "R11 no events while busy", n_sel, s0);
        bus_stop();
        busy = 1'b0;
        wc(2);
        bus_start();
        send_byte(8'hA8, ack);
        chk(ack == 1'b1, "R11 ack after busy", ack, 1);
        bus_stop();

        // R2: glitches shorter than the filter
        s0 = n_start;
        s1 = n_stop;
        bus_start();
        sda_m = 1'b1; wc(Q);
        scl_m = 1'b1; wc(2);
        sda_m = 1'b0; wc(FILT - 1);
        sda_m = 1'b1; wc(Q);
        scl_m = 1'b0; wc(Q);
        scl_m = 1'b1; wc(FILT - 1);
        scl_m = 1'b0; wc(Q);
        send_bit(1'b0, p);
        send_bit(1'b1, p);
        send_bit(1'b0, p);
        send_bit(1'b1, p);
        send_bit(1'b0, p);
        send_bit(1'b0, p);
        send_bit(1'b0, p);
        send_bit(1'b1, ack);
        chk(ack == 1'b1, "R2 glitches ignored, select acked", ack, 1);
        chk(n_start == s0 + 1 && n_stop == s1, "R2 no spurious conditions",
            n_start - s0, 1);
        bus_stop();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule